// File: doc/BRIEF.md
# Low-Power Compare Timer

A 16-bit counter with a compare match flag, an interrupt request and a hardware trigger pulse. In time-counting mode it advances once for every cycle in which the prescaler block raises its increment strobe. In pulse-counting mode it counts one edge direction on one of four external inputs. Each input is first resynchronised into the system clock domain.

Software drives the block through four 32-bit registers, addressed by word index. Index 0 is control/status, 1 is prescale, 2 is compare and 3 is counter. The enable bit also acts as a synchronous clear. The configuration fields can only be changed while the timer is stopped.

A match happens on an increment taken while the count equals the compare value. In restart mode the count returns to zero on a match. In free-running mode the count keeps going and wraps from 0xFFFF back to zero.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset all four registers read 0, and `irq` and `trig` are low.
- R2: In time mode (control bit 1 = 0) with enable (bit 0) set, the counter (index 3) rises by one on each clock edge that sees `tick_in` high. It holds when `tick_in` is low. Ticks taken while disabled leave it at 0.
- R3: When an increment arrives while the count equals compare[15:0], the flag (control bit 7) sets. If control bit 2 is 0 (restart), the count goes to 0 on that same edge.
- R4: With control bit 2 = 1 (free-run), a match still sets the flag, but the count carries on past the compare value and wraps from 0xFFFF to 0.
- R5: Writing control with bit 7 = 1 clears the flag, and writing 0 there leaves it unchanged. A match on the same edge as the clearing write wins, so the flag stays set.
- R6: Writing control with bit 0 = 0 clears the counter, the flag and `trig` on that write's clock edge, and they stay clear while disabled.
- R7: In pulse mode (bit 1 = 1), bits 5:4 select which of the `pulse_in` lines is used. Bit 3 = 0 counts rising edges and bit 3 = 1 counts falling edges. Unselected lines and `tick_in` have no effect. A count lands on the third rising clock edge after the input changes.
- R8: `irq` is high exactly when control bit 6 (interrupt enable) and the flag are both 1.
- R9: `trig` rises on a match increment and falls on the next increment. If compare is 0 it stays high until the timer is disabled.
- R10: While enable is already 1, a control write leaves bits 5:1 unchanged, but it still updates bit 6 and still acts on bits 0 and 7.
- R11: Prescale keeps write bits 6:0 and reads back zero above them. Compare keeps 15:0. Counter writes have no effect. Control bits 31:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pulse_in | input | 4 | External pulse inputs |
| tick_in | input | 1 | One-cycle increment strobe from the prescaler |
| irq | output | 1 | Interrupt request |
| trig | output | 1 | Hardware trigger |

## Verification
Register writes, `tick_in` increments, matches, flag changes and enable changes all appear one clock edge after the cycle that carries them. An input change on a pulse line appears three edges later: two synchroniser stages plus the counter register. `irq` follows the flag and the interrupt enable in the same cycle, and `reg_rdata` is valid in the cycle its index is presented.

The bench drives inputs and reads registers mid-cycle. A behavioural model is advanced on each rising edge, and `irq` and `trig` are compared against it on every falling edge. The pulse latency is checked by reading the counter two and then three edges after an input change.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned NUM_IN  = 4;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned PSC_W   = 7;

    // control register field positions (software-visible layout)
    localparam int unsigned CTL_EN     = 0;
    localparam int unsigned CTL_MODE   = 1;
    localparam int unsigned CTL_SEL_HI = 5;
    localparam int unsigned CTL_IE     = 6;
    localparam int unsigned CTL_FLAG   = 7;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_PSC  = 2'd1,
        IDX_CMP  = 2'd2,
        IDX_CNT  = 2'd3
    } reg_idx_e;

    // matches control bits 5:1 from high to low
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             pol;
        logic             free;
        logic             mode;
    } cfg_t;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       idx,
    input  logic [REG_W-1:0] wdata,
    input  logic             flag,
    input  logic [CNT_W-1:0] cnt,
    output logic             en_q,
    output logic             en_nxt,
    output logic             ie,
    output logic             w1c,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] cmp,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        logic             en;
        logic             ie;
        cfg_t             cfg;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctl;
    logic  unused_hi;

    assign unused_hi = ^wdata[REG_W-1:CNT_W];
    assign wr_ctl    = we && (idx == IDX_CTRL);

    always_comb begin
        r_d = r_q;
        if (wr_ctl) begin
            r_d.en = wdata[CTL_EN];
            r_d.ie = wdata[CTL_IE];
            if (!r_q.en) begin
                r_d.cfg = cfg_t'(wdata[CTL_SEL_HI:CTL_MODE]);
            end
        end
        if (we && (idx == IDX_PSC)) begin
            r_d.psc = wdata[PSC_W-1:0];
        end
        if (we && (idx == IDX_CMP)) begin
            r_d.cmp = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_q   = r_q.en;
    assign en_nxt = r_d.en;
    assign ie     = r_q.ie;
    assign cfg    = r_q.cfg;
    assign cmp    = r_q.cmp;
    assign w1c    = wr_ctl && wdata[CTL_FLAG];

    always_comb begin
        rdata = '0;
        case (reg_idx_e'(idx))
            IDX_CTRL: begin
                rdata[CTL_EN]                = r_q.en;
                rdata[CTL_SEL_HI:CTL_MODE]   = r_q.cfg;
                rdata[CTL_IE]                = r_q.ie;
                rdata[CTL_FLAG]              = flag;
            end
            IDX_PSC: rdata = REG_W'(r_q.psc);
            IDX_CMP: rdata = REG_W'(r_q.cmp);
            default: rdata = REG_W'(cnt);
        endcase
    end

    // R10: configuration frozen across consecutive enabled cycles
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && $past(r_q.en)) |-> (r_q.cfg == $past(r_q.cfg)));

    // R11: counter-index writes never disturb stored registers
    assert_cnt_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_CNT) |=> (r_q == $past(r_q)));
endmodule

// File: rtl/lpt_edge.sv
module lpt_edge #(
    parameter int unsigned NUM_IN      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] pin,
    output logic [NUM_IN-1:0] rise,
    output logic [NUM_IN-1:0] fall
);
    localparam int unsigned CH_W = SYNC_STAGES + 1;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic [CH_W-1:0] ch_d, ch_q;

        always_comb begin
            ch_d = {ch_q[CH_W-2:0], pin[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q <= '0;
            end else begin
                ch_q <= ch_d;
            end
        end

        assign rise[i] = ch_q[CH_W-2] & ~ch_q[CH_W-1];
        assign fall[i] = ~ch_q[CH_W-2] & ch_q[CH_W-1];

        // R7: a detected edge lasts exactly one cycle
        assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rise[i] || fall[i]) |=> !(rise[i] && fall[i]) && !($past(rise[i]) && rise[i]));
    end
endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              en_nxt,
    input  cfg_t              cfg,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              tick,
    input  logic [NUM_IN-1:0] rise,
    input  logic [NUM_IN-1:0] fall,
    input  logic              w1c,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag,
    output logic              trig
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             trig;
    } core_t;

    core_t c_d, c_q;
    logic  pulse_hit, inc, hit, cmp_zero;

    assign pulse_hit = cfg.pol ? fall[cfg.sel] : rise[cfg.sel];
    assign inc       = cfg.mode ? pulse_hit : tick;
    assign hit       = inc && (c_q.cnt == cmp);
    assign cmp_zero  = (cmp == '0);

    always_comb begin
        c_d = c_q;
        if (!en_nxt) begin
            c_d = '0;
        end else if (en_q) begin
            if (inc) begin
                c_d.trig = hit | (c_q.trig & cmp_zero);
                c_d.cnt  = (hit && !cfg.free) ? '0 : c_q.cnt + CNT_W'(1);
            end
            if (hit) begin
                c_d.flag = 1'b1;
            end else if (w1c) begin
                c_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt  = c_q.cnt;
    assign flag = c_q.flag;
    assign trig = c_q.trig;

    // R2: no increment, no movement
    assert_hold_without_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && en_nxt && !inc) |=> $stable(c_q.cnt));

    // R3: flag only rises after a matching increment
    assert_flag_from_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.flag) |-> $past(inc && c_q.cnt == cmp));

    // R5: clearing write without a concurrent match drops the flag
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && en_nxt && !hit) |=> !c_q.flag);

    // R6: disabled timer holds everything clear
    assert_disabled_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (c_q.cnt == '0 && !c_q.flag && !c_q.trig));

    // R9: zero compare keeps the trigger up while enabled
    assert_trig_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.trig && cmp_zero && en_nxt) |=> c_q.trig);
endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer
    import lpt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_IN-1:0] pulse_in,
    input  logic              tick_in,
    output logic              irq,
    output logic              trig
);
    logic              en_q, en_nxt, ie, w1c, flag;
    cfg_t              cfg;
    logic [CNT_W-1:0]  cmp, cnt;
    logic [NUM_IN-1:0] rise, fall;

    lpt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .idx    (reg_addr),
        .wdata  (reg_wdata),
        .flag   (flag),
        .cnt    (cnt),
        .en_q   (en_q),
        .en_nxt (en_nxt),
        .ie     (ie),
        .w1c    (w1c),
        .cfg    (cfg),
        .cmp    (cmp),
        .rdata  (reg_rdata)
    );

    lpt_edge #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pulse_in),
        .rise  (rise),
        .fall  (fall)
    );

    lpt_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_q   (en_q),
        .en_nxt (en_nxt),
        .cfg    (cfg),
        .cmp    (cmp),
        .tick   (tick_in),
        .rise   (rise),
        .fall   (fall),
        .w1c    (w1c),
        .cnt    (cnt),
        .flag   (flag),
        .trig   (trig)
    );

    assign irq = ie & flag;

    // R8: an interrupt request implies a pending flag
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R1: outputs quiet while disabled
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!irq && !trig));
endmodule

// File: tb/lp_cmp_timer_tb_top.sv
module lp_cmp_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wd = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pin = '0;
    logic        tick = 1'b0;
    logic        irq, trig;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_cmp_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wd),
        .reg_rdata (reg_rdata),
        .pulse_in  (pin),
        .tick_in   (tick),
        .irq       (irq),
        .trig      (trig)
    );

    // behavioural reference model
    int   m_cnt, m_cmp, m_psc;
    bit   m_en, m_mode, m_free, m_pol, m_ie, m_flag, m_trig;
    int   m_sel;
    bit [3:0] s1, s2, pp;
    bit   t_wr, t_en, t_pe, t_inc, t_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_psc = 0; m_sel = 0;
            m_en = 0; m_mode = 0; m_free = 0; m_pol = 0; m_ie = 0; m_flag = 0; m_trig = 0;
            s1 = 0; s2 = 0; pp = 0;
        end else begin
            t_wr  = we && addr == 2'd0;
            t_pe  = m_pol ? (!s2[m_sel] && pp[m_sel]) : (s2[m_sel] && !pp[m_sel]);
            t_inc = m_mode ? t_pe : tick;
            t_en  = t_wr ? wd[0] : m_en;
            if (!t_en) begin
                m_cnt = 0; m_flag = 0; m_trig = 0;
            end else if (m_en) begin
                t_hit = t_inc && (m_cnt == m_cmp);
                if (t_inc) begin
                    m_trig = t_hit || (m_trig && m_cmp == 0);
                    m_cnt  = (t_hit && !m_free) ? 0 : (m_cnt + 1) % 65536;
                end
                if (t_hit) m_flag = 1;
                else if (t_wr && wd[7]) m_flag = 0;
            end
            if (t_wr) begin
                if (!m_en) begin
                    m_mode = wd[1]; m_free = wd[2]; m_pol = wd[3]; m_sel = int'(wd[5:4]);
                end
                m_ie = wd[6];
                m_en = wd[0];
            end
            if (we && addr == 2'd1) m_psc = int'(wd[6:0]);
            if (we && addr == 2'd2) m_cmp = int'(wd[15:0]);
            pp = s2; s2 = s1; s1 = pin;
        end
    end

    function automatic logic [31:0] model_rd(logic [1:0] a);
        case (a)
            2'd0:    return {24'd0, m_flag, m_ie, 2'(m_sel), m_pol, m_free, m_mode, m_en};
            2'd1:    return 32'(m_psc);
            2'd2:    return 32'(m_cmp);
            default: return 32'(m_cnt);
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model (R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 irq vs model", 32'(irq), 32'(m_ie && m_flag));
            chk("R9 trig vs model", 32'(trig), 32'(m_trig));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wd = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdchk(string tag, logic [1:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, model_rd(a));
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        cyc(n);
        tick = 1'b0;
    endtask

    task automatic pulse(int i);
        pin[i] = 1'b1;
        cyc(4);
        pin[i] = 1'b0;
        cyc(4);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rdchk("R1 ctrl", 2'd0, 32'h0);
        rdchk("R1 psc", 2'd1, 32'h0);
        rdchk("R1 cmp", 2'd2, 32'h0);
        rdchk("R1 cnt", 2'd3, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 trig", 32'(trig), 32'h0);

        // R11 register widths
        wr(2'd1, 32'hFFFF_FFFF);
        rdchk("R11 psc", 2'd1, 32'h7F);
        wr(2'd2, 32'hABCD_1234);
        rdchk("R11 cmp", 2'd2, 32'h1234);
        wr(2'd3, 32'h55);
        rdchk("R11 cnt write", 2'd3, 32'h0);
        wr(2'd0, 32'hFFFF_FF00);
        rdchk("R11 ctrl hi", 2'd0, 32'h0);

        // R2 time mode
        ticks(3);
        rdchk("R2 off ticks", 2'd3, 32'h0);
        wr(2'd2, 32'd5);
        wr(2'd0, 32'h01);
        ticks(3);
        rdchk("R2 count", 2'd3, 32'd3);
        cyc(2);
        rdchk("R2 hold", 2'd3, 32'd3);

        // R3 match in restart mode
        ticks(2);
        ticks(1);
        rdchk("R3 restart", 2'd3, 32'd0);
        rdchk("R3 flag", 2'd0, 32'h81);
        chk("R8 no ie", 32'(irq), 32'h0);

        // R9 trigger width
        cyc(2);
        chk("R9 trig held", 32'(trig), 32'h1);
        ticks(1);
        chk("R9 trig drop", 32'(trig), 32'h0);
        rdchk("R9 cnt", 2'd3, 32'd1);

        // R5 write-one-to-clear
        wr(2'd0, 32'h01);
        rdchk("R5 zero keeps", 2'd0, 32'h81);
        wr(2'd0, 32'h81);
        rdchk("R5 clear", 2'd0, 32'h01);
        ticks(4);
        tick = 1'b1;
        wr(2'd0, 32'h81);
        tick = 1'b0;
        rdchk("R5 set wins", 2'd0, 32'h81);

        // R8 interrupt
        wr(2'd0, 32'hC1);
        chk("R8 cleared", 32'(irq), 32'h0);
        rdchk("R8 ctrl", 2'd0, 32'h41);
        ticks(6);
        chk("R8 irq", 32'(irq), 32'h1);

        // R10 config lock while enabled
        wr(2'd0, 32'h7F);
        rdchk("R10 locked", 2'd0, 32'hC1);

        // R6 disable clears
        wr(2'd0, 32'h00);
        rdchk("R6 ctrl", 2'd0, 32'h0);
        rdchk("R6 cnt", 2'd3, 32'h0);
        chk("R6 trig", 32'(trig), 32'h0);

        // R4 free-run past compare and wrap
        wr(2'd2, 32'd3);
        wr(2'd0, 32'h05);
        ticks(4);
        rdchk("R4 past cmp", 2'd3, 32'd4);
        rdchk("R4 flag", 2'd0, 32'h85);
        ticks(65532);
        rdchk("R4 wrap", 2'd3, 32'd0);
        wr(2'd0, 32'h00);

        // R9 zero compare keeps trigger
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h05);
        ticks(1);
        chk("R9 zero rise", 32'(trig), 32'h1);
        ticks(5);
        chk("R9 zero hold", 32'(trig), 32'h1);
        rdchk("R9 zero cnt", 2'd3, 32'd6);
        wr(2'd0, 32'h00);
        chk("R9 zero off", 32'(trig), 32'h0);

        // R7 pulse mode, rising edges on input 2
        wr(2'd2, 32'd100);
        wr(2'd0, 32'h23);
        tick = 1'b1;
        pin[2] = 1'b1;
        cyc(2);
        rdchk("R7 latency before", 2'd3, 32'd0);
        cyc(1);
        rdchk("R7 latency at", 2'd3, 32'd1);
        pin[2] = 1'b0;
        cyc(4);
        pulse(1);
        pulse(1);
        pulse(2);
        pulse(2);
        tick = 1'b0;
        rdchk("R7 rising", 2'd3, 32'd3);
        rdchk("R7 ctrl", 2'd0, 32'h23);

        // R7 falling edges
        wr(2'd0, 32'h00);
        wr(2'd0, 32'h2B);
        pin[2] = 1'b1;
        cyc(4);
        rdchk("R7 rise ignored", 2'd3, 32'd0);
        pin[2] = 1'b0;
        cyc(4);
        pulse(3);
        pulse(2);
        rdchk("R7 falling", 2'd3, 32'd2);
        wr(2'd0, 32'h00);
        cyc(2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule